// File: doc/BRIEF.md
# Shared Memory Bank Conflict Replayer

This block takes one shared-memory access for a whole warp and spreads it across several single-ported SRAM banks. Each lane has a word address, an active bit and a common read or write type. The low address bits pick a bank and the upper bits pick a row inside that bank. In each cycle, every bank serves one row. Lanes that need a different row of a bank that is already taken wait for a later round. The instruction pipeline never stalls. It simply sees the access finish after a number of rounds that is known on the first cycle.

When the access is accepted, the block works out how many rounds the warp needs and reserves a writeback slot at a fixed distance. It then issues one round per cycle, with no gaps. Each round drives a per-bank enable and row along with the mask of lanes it serves. Read words come back one cycle after their round, each routed to the lane that asked for it. Lanes that read the same word of a bank share a round and all receive that word. The block reports the number of rounds it used in the final round, and it accepts a new access in the cycle after that.

Top module: `smem_replay_unit`

## Requirements
- R1: A lane's bank is its word address modulo BANKS, which is the low log2(BANKS) address bits. Its row is the remaining upper bits. With 8 banks, address 8*r+3 is bank 3, row r.
- R2: In every round each bank is enabled for at most one row. Lanes that target distinct banks are all served in the first round, so eight consecutive addresses take one round with all eight bank enables set.
- R3: Active lanes that address the same row of the same bank are served in the same round. On a read, every one of them receives the same word.
- R4: Lanes that conflict are replayed in later rounds. The rounds follow one per cycle, with no idle cycle, starting in the cycle after acceptance.
- R5: When several rows of one bank are pending, the round serves the row of the lowest-numbered pending lane in that bank.
- R6: In the acceptance cycle, wbReserve pulses and wbRounds gives the round count. That count is the largest number of distinct rows requested in any single bank. The final response (respLast) appears exactly wbRounds+1 cycles after the acceptance cycle.
- R7: One cycle after each round, respValid is high and respLaneMask equals that round's lane mask. For a read, each served lane's slice of respData holds its word, and every other slice is zero. For a write, respData is zero.
- R8: A write stores each served lane's data at its address. When several lanes write the same address, the lowest-numbered lane's data is kept.
- R9: reqReady is low from the cycle after acceptance through the final round, and high again in the cycle after it. doneValid is high in the final round, and doneRounds equals the number of rounds issued.
- R10: Inactive lanes are never served and cause no conflict. A request with no active lane is accepted with wbRounds equal to 0, issues no round, and leaves reqReady high.
- R11: After reset, reqReady is high and rndValid, respValid and doneValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Warp access offered |
| reqReady | output | 1 | Block can accept an access |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqMask | input | LANES (8) | Active lanes |
| reqAddr | input | LANES*ADDR_W (64) | Per-lane word address, lane 0 in the low bits |
| reqWdata | input | LANES*DATA_W (256) | Per-lane store data |
| wbReserve | output | 1 | Writeback slot reserved (acceptance cycle) |
| wbRounds | output | CNT_W (4) | Rounds the accepted access will take |
| rndValid | output | 1 | A round is issued this cycle |
| rndWrite | output | 1 | Type of the issued round |
| rndLaneMask | output | LANES (8) | Lanes served in this round |
| rndBankEn | output | BANKS (8) | Banks accessed in this round |
| rndBankRow | output | BANKS*ROW_W (40) | Row per bank, bank 0 in the low bits |
| respValid | output | 1 | Response for the previous round |
| respLast | output | 1 | Response of the final round |
| respLaneMask | output | LANES (8) | Lanes covered by the response |
| respData | output | LANES*DATA_W (256) | Per-lane read words |
| doneValid | output | 1 | Final round of the access |
| doneRounds | output | CNT_W (4) | Rounds used by the access |

## Verification
In a single round, the block can both broadcast one word to lanes that share a row and defer other lanes of the same bank to a replay. The mixed-pattern test sets this up with two lanes on bank 3 row 0, two on row 1, one on row 2, and three lanes on other banks. The bench checks that the first round serves the shared-row pair together with the unrelated banks. It also checks that the row-1 pair follows as one group and the row-2 lane comes last. The read data must match the bench's memory model for each lane. The total round count must agree with wbRounds, doneRounds and the timing of respLast.

// File: rtl/smem_replay_pkg.sv
package smem_replay_pkg;

  // Strobes from the control FSM into the datapath.
  typedef struct packed {
    logic loadReq;   // capture the offered warp access
    logic advance;   // retire the lanes served in the current round
  } ctlStrobe_t;

endpackage

// File: rtl/smem_bank_pick.sv
// Round selection for one bank: the row of the lowest pending lane in this
// bank wins, and every pending lane on that same row is served with it.
module smem_bank_pick #(
  parameter int LANES   = 8,
  parameter int ADDR_W  = 8,
  parameter int BANK_W  = 3,
  parameter int BANK_ID = 0,
  localparam int ROW_W  = ADDR_W - BANK_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]        pendMask,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  output logic [LANES-1:0]        grant,
  output logic                    bankEn,
  output logic [ROW_W-1:0]        bankRow,
  output logic [LIDX_W-1:0]       leadLane
);

  logic [BANK_W-1:0] myBank;
  assign myBank = BANK_W'(BANK_ID);

  always_comb begin
    bankEn   = 1'b0;
    bankRow  = '0;
    leadLane = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!bankEn && pendMask[l] && laneAddr[l*ADDR_W +: BANK_W] == myBank) begin
        bankEn   = 1'b1;
        bankRow  = laneAddr[l*ADDR_W+BANK_W +: ROW_W];
        leadLane = LIDX_W'(l);
      end
    end
    for (int l = 0; l < LANES; l++) begin
      grant[l] = bankEn && pendMask[l]
                 && laneAddr[l*ADDR_W +: BANK_W] == myBank
                 && laneAddr[l*ADDR_W+BANK_W +: ROW_W] == bankRow;
    end
  end

endmodule

// File: rtl/smem_replay_datapath.sv
module smem_replay_datapath
  import smem_replay_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int BANKS  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BANK_W,
  localparam int ROWS   = 1 << ROW_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              strobe,
  input  logic                    reqWrite,
  input  logic [LANES-1:0]        reqMask,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES*DATA_W-1:0] reqWdata,
  output logic [CNT_W-1:0]        acceptRounds,
  output logic                    lastRound,
  output logic                    rndWrite,
  output logic [LANES-1:0]        rndLaneMask,
  output logic [BANKS-1:0]        rndBankEn,
  output logic [BANKS*ROW_W-1:0]  rndBankRow,
  output logic                    respValid,
  output logic                    respLast,
  output logic [LANES-1:0]        respLaneMask,
  output logic [LANES*DATA_W-1:0] respData
);

  logic [LANES*ADDR_W-1:0] addrQ;
  logic [LANES*DATA_W-1:0] wdataQ;
  logic                    writeQ;
  logic [LANES-1:0]        pendQ;

  logic [LANES-1:0]  bankGrant [BANKS];
  logic [DATA_W-1:0] rdWord    [BANKS];
  logic [LANES-1:0]  grantAll;

  // Captured request and pending-lane set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
      pendQ  <= '0;
    end else if (strobe.loadReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
      pendQ  <= reqMask;
    end else if (strobe.advance) begin
      pendQ  <= pendQ & ~grantAll;
    end
  end

  // Per-bank row pick and the bank array itself.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LANES-1:0]  grant;
    logic              en;
    logic [ROW_W-1:0]  row;
    logic [LIDX_W-1:0] lead;
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rdQ;

    smem_bank_pick #(
      .LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_ID(b)
    ) pick_i (
      .pendMask(pendQ), .laneAddr(addrQ),
      .grant(grant), .bankEn(en), .bankRow(row), .leadLane(lead)
    );

    always_ff @(posedge clk) begin
      if (strobe.advance && en && writeQ)
        mem[row] <= wdataQ[lead*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rdQ <= '0;
      else if (strobe.advance && en && !writeQ)
        rdQ <= mem[row];
    end

    assign bankGrant[b]                 = grant;
    assign rdWord[b]                    = rdQ;
    assign rndBankEn[b]                 = en;
    assign rndBankRow[b*ROW_W +: ROW_W] = row;
  end

  always_comb begin
    grantAll = '0;
    for (int b = 0; b < BANKS; b++) grantAll = grantAll | bankGrant[b];
  end

  assign lastRound   = (pendQ & ~grantAll) == '0;
  assign rndLaneMask = grantAll;
  assign rndWrite    = writeQ;

  // Round count of an offered request: largest number of distinct rows
  // claimed in any one bank.
  logic [LANES-1:0] rowLeader;
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rowLeader[l] = reqMask[l];
      for (int j = 0; j < l; j++) begin
        if (reqMask[j] && reqAddr[j*ADDR_W +: ADDR_W] == reqAddr[l*ADDR_W +: ADDR_W])
          rowLeader[l] = 1'b0;
      end
    end
  end

  always_comb begin
    logic [CNT_W-1:0] perBank;
    acceptRounds = '0;
    for (int b = 0; b < BANKS; b++) begin
      perBank = '0;
      for (int l = 0; l < LANES; l++) begin
        if (rowLeader[l] && reqAddr[l*ADDR_W +: BANK_W] == BANK_W'(b))
          perBank = perBank + CNT_W'(1);
      end
      if (perBank > acceptRounds) acceptRounds = perBank;
    end
  end

  // Response stage, one cycle behind the round.
  logic             respValidQ;
  logic             respLastQ;
  logic             respWriteQ;
  logic [LANES-1:0] respMaskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValidQ <= 1'b0;
      respLastQ  <= 1'b0;
      respWriteQ <= 1'b0;
      respMaskQ  <= '0;
    end else begin
      respValidQ <= strobe.advance;
      respLastQ  <= strobe.advance && lastRound;
      respWriteQ <= writeQ;
      respMaskQ  <= strobe.advance ? grantAll : '0;
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (respValidQ && !respWriteQ && respMaskQ[l])
        respData[l*DATA_W +: DATA_W] = rdWord[addrQ[l*ADDR_W +: BANK_W]];
      else
        respData[l*DATA_W +: DATA_W] = '0;
    end
  end

  assign respValid    = respValidQ;
  assign respLast     = respLastQ;
  assign respLaneMask = respMaskQ;

endmodule

// File: rtl/smem_replay_control.sv
module smem_replay_control
  import smem_replay_pkg::*;
#(
  parameter int LANES = 8,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqAny,
  input  logic             lastRound,
  output logic             reqReady,
  output logic             accept,
  output ctlStrobe_t       strobe,
  output logic             busy,
  output logic             doneValid,
  output logic [CNT_W-1:0] doneRounds
);

  typedef enum logic {ST_IDLE, ST_REPLAY} state_t;
  state_t           stateQ;
  logic [CNT_W-1:0] roundCntQ;

  assign reqReady       = stateQ == ST_IDLE;
  assign accept         = reqValid && reqReady;
  assign busy           = stateQ == ST_REPLAY;
  assign strobe.loadReq = accept;
  assign strobe.advance = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      roundCntQ <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          roundCntQ <= '0;
          if (accept && reqAny) stateQ <= ST_REPLAY;
        end
        ST_REPLAY: begin
          roundCntQ <= roundCntQ + CNT_W'(1);
          if (lastRound) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign doneValid  = busy && lastRound;
  assign doneRounds = roundCntQ + CNT_W'(1);

endmodule

// File: rtl/smem_replay_unit.sv
module smem_replay_unit
  import smem_replay_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int BANKS  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BANK_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [LANES-1:0]        reqMask,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES*DATA_W-1:0] reqWdata,
  output logic                    wbReserve,
  output logic [CNT_W-1:0]        wbRounds,
  output logic                    rndValid,
  output logic                    rndWrite,
  output logic [LANES-1:0]        rndLaneMask,
  output logic [BANKS-1:0]        rndBankEn,
  output logic [BANKS*ROW_W-1:0]  rndBankRow,
  output logic                    respValid,
  output logic                    respLast,
  output logic [LANES-1:0]        respLaneMask,
  output logic [LANES*DATA_W-1:0] respData,
  output logic                    doneValid,
  output logic [CNT_W-1:0]        doneRounds
);

  ctlStrobe_t strobe;
  logic       lastRound;
  logic       accept;

  smem_replay_control #(.LANES(LANES)) ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAny(|reqMask),
    .lastRound(lastRound), .reqReady(reqReady), .accept(accept),
    .strobe(strobe), .busy(rndValid), .doneValid(doneValid),
    .doneRounds(doneRounds)
  );

  smem_replay_datapath #(
    .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqMask(reqMask), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .acceptRounds(wbRounds), .lastRound(lastRound), .rndWrite(rndWrite),
    .rndLaneMask(rndLaneMask), .rndBankEn(rndBankEn), .rndBankRow(rndBankRow),
    .respValid(respValid), .respLast(respLast), .respLaneMask(respLaneMask),
    .respData(respData)
  );

  assign wbReserve = accept;

endmodule

// File: rtl/smem_replay_checker.sv
module smem_replay_checker #(
  parameter int LANES = 8,
  parameter int BANKS = 8,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [LANES-1:0] reqMask,
  input logic [CNT_W-1:0] wbRounds,
  input logic             rndValid,
  input logic [LANES-1:0] rndLaneMask,
  input logic [BANKS-1:0] rndBankEn,
  input logic             respValid,
  input logic             respLast,
  input logic [LANES-1:0] respLaneMask,
  input logic             doneValid,
  input logic [CNT_W-1:0] doneRounds
);

  logic             acc;
  logic [CNT_W:0]   lastCntQ;
  logic [CNT_W-1:0] savedQ;

  assign acc = reqValid && reqReady && (reqMask != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCntQ <= '0;
      savedQ   <= '0;
    end else if (acc) begin
      lastCntQ <= {1'b0, wbRounds} + (CNT_W+1)'(1);
      savedQ   <= wbRounds;
    end else if (lastCntQ != '0) begin
      lastCntQ <= lastCntQ - (CNT_W+1)'(1);
    end
  end

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    rndValid |-> !reqReady);

  a_r4_first_round_next: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> rndValid);

  a_r4_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (rndValid && !doneValid) |=> rndValid);

  a_r2_round_serves: assert property (@(posedge clk) disable iff (!rstN)
    rndValid |-> (rndLaneMask != '0 && rndBankEn != '0));

  a_r6_done_matches_reserve: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> doneRounds == savedQ);

  a_r6_last_on_time: assert property (@(posedge clk) disable iff (!rstN)
    respLast |-> lastCntQ == (CNT_W+1)'(1));

  a_r6_last_not_missed: assert property (@(posedge clk) disable iff (!rstN)
    lastCntQ == (CNT_W+1)'(1) |-> respLast);

  a_r7_resp_follows_round: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($past(rndValid) && respLaneMask == $past(rndLaneMask)));

  a_r10_empty_no_round: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqMask == '0) |=> (!rndValid && reqReady));

endmodule

bind smem_replay_unit smem_replay_checker #(.LANES(LANES), .BANKS(BANKS)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqMask(reqMask), .wbRounds(wbRounds), .rndValid(rndValid),
  .rndLaneMask(rndLaneMask), .rndBankEn(rndBankEn), .respValid(respValid),
  .respLast(respLast), .respLaneMask(respLaneMask), .doneValid(doneValid),
  .doneRounds(doneRounds)
);

// File: tb/smem_replay_unit_tb_top.sv
`timescale 1ns/1ps
module smem_replay_unit_tb_top;

  localparam int LANES = 8, BANKS = 8, ADDR_W = 8, DATA_W = 32;
  localparam int ROW_W = 5, CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic                    reqValid = 1'b0, reqWrite = 1'b0;
  logic [LANES-1:0]        reqMask = '0;
  logic [LANES*ADDR_W-1:0] reqAddr = '0;
  logic [LANES*DATA_W-1:0] reqWdata = '0;
  logic                    reqReady, wbReserve, rndValid, rndWrite;
  logic [CNT_W-1:0]        wbRounds, doneRounds;
  logic [LANES-1:0]        rndLaneMask, respLaneMask;
  logic [BANKS-1:0]        rndBankEn;
  logic [BANKS*ROW_W-1:0]  rndBankRow;
  logic                    respValid, respLast, doneValid;
  logic [LANES*DATA_W-1:0] respData;

  smem_replay_unit dut_i (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [7:0]  tAddr [LANES];
  logic [31:0] tData [LANES];
  logic [31:0] memModel [256];
  logic [7:0]  expMask [LANES];
  int          expRounds;
  int          extraMode;   // 0 none, 1 all banks, 2 bank-3 stride

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected round grouping from the rules in R2, R3, R5, R10.
  task automatic modelRounds(input logic [7:0] m);
    logic [7:0] pend = m;
    expRounds = 0;
    while (pend != 0) begin
      logic [7:0] g = 0;
      for (int b = 0; b < BANKS; b++) begin
        bit found = 0;
        logic [4:0] row = 0;
        for (int l = 0; l < LANES; l++)
          if (!found && pend[l] && tAddr[l][2:0] == b[2:0]) begin
            found = 1; row = tAddr[l][7:3];
          end
        for (int l = 0; l < LANES; l++)
          if (found && pend[l] && tAddr[l][2:0] == b[2:0] && tAddr[l][7:3] == row)
            g[l] = 1'b1;
      end
      expMask[expRounds] = g;
      expRounds++;
      pend = pend & ~g;
    end
  endtask

  task automatic runAccess(input logic wr, input logic [7:0] m, input string name);
    modelRounds(m);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqMask = m;
    for (int l = 0; l < LANES; l++) begin
      reqAddr[l*ADDR_W +: ADDR_W]  = tAddr[l];
      reqWdata[l*DATA_W +: DATA_W] = tData[l];
    end
    #1;
    chk(reqReady === 1'b1, "R9", {name, " ready at offer"}, reqReady, 1);
    chk(wbReserve === 1'b1 && wbRounds == CNT_W'(expRounds), "R6",
        {name, " reserved rounds"}, wbRounds, expRounds);
    @(negedge clk);
    reqValid = 1'b0;
    if (expRounds == 0) begin
      chk(!rndValid && reqReady, "R10", {name, " empty: no round, ready"},
          {rndValid, reqReady}, 2'b01);
      return;
    end
    for (int cyc = 1; cyc <= expRounds + 1; cyc++) begin
      if (cyc > 1) @(negedge clk);
      if (cyc <= expRounds) begin
        chk(rndValid === 1'b1, "R4", {name, " round issued"}, rndValid, 1);
        chk(rndLaneMask == expMask[cyc-1], "R5", {name, " round lanes"},
            rndLaneMask, expMask[cyc-1]);
        chk(doneValid == (cyc == expRounds), "R9", {name, " done flag"},
            doneValid, cyc == expRounds);
        if (cyc == expRounds)
          chk(doneRounds == CNT_W'(expRounds), "R9", {name, " done count"},
              doneRounds, expRounds);
        if (extraMode == 1)
          chk(rndBankEn == 8'hFF, "R2", {name, " all banks enabled"}, rndBankEn, 8'hFF);
        if (extraMode == 2) begin
          chk(rndBankEn == 8'h08, "R1", {name, " only bank 3"}, rndBankEn, 8'h08);
          chk(rndBankRow[3*ROW_W +: ROW_W] == ROW_W'(cyc-1), "R1", {name, " bank 3 row"},
              rndBankRow[3*ROW_W +: ROW_W], cyc-1);
        end
      end else begin
        chk(!rndValid && reqReady, "R9", {name, " idle and ready after last"},
            {rndValid, reqReady}, 2'b01);
      end
      if (cyc >= 2) begin
        chk(respValid && respLaneMask == expMask[cyc-2], "R7", {name, " response lanes"},
            respLaneMask, expMask[cyc-2]);
        chk(respLast == (cyc == expRounds + 1), "R6", {name, " last response timing"},
            respLast, cyc == expRounds + 1);
        for (int l = 0; l < LANES; l++) begin
          logic [31:0] e;
          e = (!wr && expMask[cyc-2][l]) ? memModel[tAddr[l]] : 32'h0;
          chk(respData[l*DATA_W +: DATA_W] == e, wr ? "R7" : "R3",
              {name, $sformatf(" lane %0d data", l)}, respData[l*DATA_W +: DATA_W], e);
        end
      end
    end
    if (wr)
      for (int l = LANES - 1; l >= 0; l--)
        if (m[l]) memModel[tAddr[l]] = tData[l];   // R8: lowest lane kept
    extraMode = 0;
  endtask

  task automatic testReset();
    #1;
    chk(reqReady && !rndValid && !respValid && !doneValid, "R11", "reset state",
        {reqReady, rndValid, respValid, doneValid}, 4'b1000);
  endtask

  task automatic testConsecutive();
    for (int l = 0; l < LANES; l++) begin
      tAddr[l] = 8'(l); tData[l] = 32'hC0DE_0000 + 32'(l * 17);
    end
    extraMode = 1;
    runAccess(1'b1, 8'hFF, "R2 consecutive write");
    runAccess(1'b0, 8'hFF, "R7 consecutive read");
  endtask

  task automatic testBroadcast();
    for (int l = 0; l < LANES; l++) tAddr[l] = 8'd5;
    runAccess(1'b0, 8'hFF, "R3 broadcast read");
  endtask

  task automatic testStride();
    for (int l = 0; l < LANES; l++) begin
      tAddr[l] = 8'(l * 8 + 3); tData[l] = 32'h5EED_0100 + 32'(l);
    end
    extraMode = 2;
    runAccess(1'b1, 8'hFF, "R1 stride write");
    extraMode = 2;
    runAccess(1'b0, 8'hFF, "R4 stride read");
  endtask

  task automatic testMixed();
    tAddr[0] = 3;  tAddr[1] = 3;  tAddr[2] = 11; tAddr[3] = 19;
    tAddr[4] = 11; tAddr[5] = 1;  tAddr[6] = 2;  tAddr[7] = 4;
    runAccess(1'b0, 8'hFF, "R5 mixed read");
    chk(expRounds == 3 && expMask[0] == 8'hE3 && expMask[1] == 8'h14 && expMask[2] == 8'h08,
        "R5", "mixed pattern grouping", expMask[0], 8'hE3);
  endtask

  task automatic testSameAddrWrite();
    for (int l = 0; l < LANES; l++) begin
      tAddr[l] = 8'd40; tData[l] = 32'hBEEF_0000 + 32'(l);
    end
    runAccess(1'b1, 8'b1111_1010, "R8 same-address write");
    runAccess(1'b0, 8'h01, "R8 read back winner");
    chk(memModel[40] == 32'hBEEF_0001, "R8", "lowest active writer kept",
        memModel[40], 32'hBEEF_0001);
  endtask

  task automatic testInactive();
    tAddr[0] = 0; tAddr[1] = 8; tAddr[2] = 2;
    for (int l = 3; l < LANES; l++) tAddr[l] = 8'(8 * l);
    runAccess(1'b0, 8'b0000_0101, "R10 inactive lanes");
    chk(expRounds == 1, "R10", "inactive lane causes no replay", expRounds, 1);
    runAccess(1'b0, 8'h00, "R10 empty request");
  endtask

  initial begin
    extraMode = 0;
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testConsecutive();
    testBroadcast();
    testStride();
    testMixed();
    testSameAddrWrite();
    testInactive();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule